// File: doc/BRIEF.md
# One-Shot Continuation Record Engine

This block saves and restores the architectural state of a small tagged-register core through continuation records held in its own RAM region. A capture request carries the address of a perform instruction, the stack pointer, the prompt stack pointer, eight tagged registers, the effect argument and a 4-bit effect op. The engine takes a slot, writes a one-word header and a twenty-word payload into the slot, then returns the register file as the handler will see it: v0 holds the argument, v1 holds a CONT-tagged handle to the record, and v7 holds the op as an INT.

A resume request carries a handle and a delivered value. The engine checks that the handle is a CONT-tagged pointer to the start of a record payload, reads the header and traps if the record has already been consumed. Otherwise it sets the consumed mark in the header, reads the saved state back, returns the slot to a last-in first-out free list and presents the restored registers, PC and SP, with v0 replaced by the delivered value. Each record can be resumed once only.

Slots are `32` words apart starting at `REGION_BASE`. The handle of slot `s` is `REGION_BASE + 32*s + 1`, and the header sits one word below it. Header bits [15:8] hold the consumed mark (0x00 fresh, 0x01 consumed), bits [7:4] hold 15, and bits [3:0] hold a fixed layout code. The first payload word holds 20, the payload length counting itself. The remaining payload words are, in order: saved PC, SP, prompt SP, v6 value, v6 tag, value/tag pairs for v0 through v5, then v7 value and tag.

Top module: `cont_rec_engine`

## Requirements
- R1: After reset, idle_o is 1 and cap_done_o, res_done_o, trap_o and exhaust_o are 0.
- R2: A capture with slots available returns the handle REGION_BASE + 32*slot + 1 in v1. Fresh slots are handed out in ascending order from slot 0.
- R3: On a successful capture, v0 equals the argument (value and tag), v1 has tag 2 (CONT), v7 is the zero-extended op with tag 0 (INT), v2..v6 equal the supplied registers, pc_o equals the perform PC plus 1, and sp_o equals the supplied SP.
- R4: A successful resume presents v1..v7 exactly as captured, presents v0 as the delivered value and tag, and presents the saved PC and SP on pc_o and sp_o.
- R5: A resume whose handle tag is not 2 (CONT) ends with res_done_o and trap_o in the cycle after the start.
- R6: A resume traps when the handle lies outside the region or does not point at a payload start (low 5 bits not equal to 1).
- R7: A second resume of the same handle, with no capture into that slot in between, traps.
- R8: A capture takes the most recently freed slot before any fresh slot.
- R9: When every slot holds a live record, a capture ends with cap_done_o and exhaust_o and writes nothing. All live records still resume intact.
- R10: A slot reclaimed by resume can be captured again, and the new record resumes with its own contents.
- R11: cap_done_o and res_done_o are single-cycle pulses that never coincide. trap_o is asserted only with res_done_o, and exhaust_o only with cap_done_o. idle_o is 0 from the cycle after an accepted start until the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_start_i | input | 1 | Start a capture; accepted when idle, has priority over resume |
| cap_pc_i | input | 16 | Address of the perform instruction |
| cap_sp_i | input | 16 | Stack pointer to save |
| cap_psp_i | input | 16 | Prompt stack pointer to save |
| cap_reg_val_i | input | 128 | Values of v0..v7, v0 in bits [15:0] |
| cap_reg_tag_i | input | 24 | Tags of v0..v7, v0 in bits [2:0] |
| cap_arg_val_i | input | 16 | Effect argument value |
| cap_arg_tag_i | input | 3 | Effect argument tag |
| cap_op_i | input | 4 | Effect op |
| res_start_i | input | 1 | Start a resume; accepted when idle |
| res_handle_val_i | input | 16 | Handle address |
| res_handle_tag_i | input | 3 | Handle tag |
| res_value_val_i | input | 16 | Delivered value |
| res_value_tag_i | input | 3 | Delivered tag |
| idle_o | output | 1 | Engine is idle and accepts a start |
| cap_done_o | output | 1 | Capture finished (pulse) |
| res_done_o | output | 1 | Resume finished (pulse) |
| exhaust_o | output | 1 | Capture found no free slot (with cap_done_o) |
| trap_o | output | 1 | Resume rejected (with res_done_o) |
| reg_val_o | output | 128 | Register values after the operation |
| reg_tag_o | output | 24 | Register tags after the operation |
| pc_o | output | 16 | Saved PC (capture) or restored PC (resume) |
| sp_o | output | 16 | Saved SP (capture) or restored SP (resume) |

## Verification
The assertions assume that a start is raised only while idle_o is high and is held for exactly one cycle. If both starts are raised together, only the capture is taken. The bench drives each start for a single cycle at a falling edge and waits for the matching done pulse before issuing the next request, so no start is ever presented to a busy engine. The bench resumes only handles it has received from a capture, or handles that fail the tag or address check. As a result, the header of a slot that has never been written is never read.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int DW   = 16;
  localparam int TW   = 3;
  localparam int NREG = 8;

  localparam int PAYLOAD_WORDS = 20;
  localparam int REC_WORDS     = PAYLOAD_WORDS + 1;
  localparam int OFFW          = $clog2(REC_WORDS);

  localparam logic [TW-1:0] TAG_INT  = 3'd0;
  localparam logic [TW-1:0] TAG_CONT = 3'd2;

  localparam logic [3:0] LAYOUT_CONT = 4'd3;
  localparam logic [3:0] SIZE_ESC    = 4'hF;
  localparam logic [7:0] MARK_FRESH  = 8'h00;
  localparam logic [7:0] MARK_USED   = 8'h01;

  // word offsets inside a slot
  localparam int OFF_HDR  = 0;
  localparam int OFF_SIZE = 1;
  localparam int OFF_PC   = 2;
  localparam int OFF_SP   = 3;
  localparam int OFF_PSP  = 4;
  localparam int OFF_LAST = REC_WORDS - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_CAPW, S_RHDR, S_RCHK, S_RRD, S_RDRAIN, S_FIN
  } seq_state_e;

  // register held by a register word: 5,6 -> v6; 7..18 -> v0..v5; 19,20 -> v7
  // odd offsets hold values, even offsets hold tags
  function automatic logic [2:0] off_reg(input logic [OFFW-1:0] off);
    if (off < OFFW'(7))       return 3'd6;
    else if (off < OFFW'(19)) return 3'((off - OFFW'(7)) >> 1);
    else                      return 3'd7;
  endfunction
endpackage

// File: rtl/cre_ram.sv
module cre_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/cre_slot_pool.sv
module cre_slot_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int SW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [SW-1:0] push_slot_i,
  output logic          avail_o,
  output logic [SW-1:0] pop_slot_o
);
  localparam int CW = $clog2(NUM_SLOTS + 1);

  logic [SW-1:0] free_q [NUM_SLOTS];
  logic [CW-1:0] fcnt_q;
  logic [CW-1:0] fresh_q;
  logic [SW-1:0] top_idx;

  assign top_idx    = SW'(fcnt_q - CW'(1));
  assign avail_o    = (fcnt_q != '0) || (fresh_q != CW'(NUM_SLOTS));
  assign pop_slot_o = (fcnt_q != '0) ? free_q[top_idx] : SW'(fresh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q  <= '0;
      fresh_q <= '0;
    end else if (pop_i) begin
      if (fcnt_q != '0) fcnt_q <= fcnt_q - CW'(1);
      else              fresh_q <= fresh_q + CW'(1);
    end else if (push_i) begin
      fcnt_q <= fcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !pop_i) free_q[SW'(fcnt_q)] <= push_slot_i;
  end
endmodule

// File: rtl/cre_seq.sv
module cre_seq import cre_pkg::*; #(
  parameter int            NUM_SLOTS   = 4,
  parameter logic [DW-1:0] REGION_BASE = 16'hC000,
  parameter int            SW          = 2,
  parameter int            AW          = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_start_i,
  input  logic [DW-1:0]      cap_pc_i,
  input  logic [DW-1:0]      cap_sp_i,
  input  logic [DW-1:0]      cap_psp_i,
  input  logic [NREG*DW-1:0] cap_reg_val_i,
  input  logic [NREG*TW-1:0] cap_reg_tag_i,
  input  logic [DW-1:0]      cap_arg_val_i,
  input  logic [TW-1:0]      cap_arg_tag_i,
  input  logic [3:0]         cap_op_i,
  input  logic               res_start_i,
  input  logic [DW-1:0]      res_handle_val_i,
  input  logic [TW-1:0]      res_handle_tag_i,
  input  logic [DW-1:0]      res_value_val_i,
  input  logic [TW-1:0]      res_value_tag_i,
  input  logic               avail_i,
  input  logic [SW-1:0]      pop_slot_i,
  output logic               pop_o,
  output logic               push_o,
  output logic [SW-1:0]      push_slot_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               idle_o,
  output logic               cap_done_o,
  output logic               res_done_o,
  output logic               exhaust_o,
  output logic               trap_o,
  output logic [NREG*DW-1:0] reg_val_o,
  output logic [NREG*TW-1:0] reg_tag_o,
  output logic [DW-1:0]      pc_o,
  output logic [DW-1:0]      sp_o
);
  seq_state_e        state_q;
  logic              is_cap_q, flag_q;
  logic [SW-1:0]     slot_q;
  logic [OFFW-1:0]   cnt_q, rd_off_q;
  logic              rd_pend_q;
  logic [DW-1:0]     pc_q, sp_q, psp_q;
  logic [NREG*DW-1:0] regv_q, out_val_q;
  logic [NREG*TW-1:0] regt_q, out_tag_q;
  logic [DW-1:0]     out_pc_q, out_sp_q, dv_q;
  logic [TW-1:0]     dt_q;

  // capture-side combinational values
  logic [DW-1:0]      new_handle;
  logic [NREG*DW-1:0] cap_out_val;
  logic [NREG*TW-1:0] cap_out_tag;
  logic [SW-1:0]      res_slot;
  logic               res_ok;
  logic               hdr_ok;
  logic [2:0]         wr_reg, rd_reg;
  logic [DW-1:0]      cap_word;

  assign new_handle = REGION_BASE + DW'({pop_slot_i, OFFW'(1)});

  always_comb begin
    cap_out_val = cap_reg_val_i;
    cap_out_tag = cap_reg_tag_i;
    cap_out_val[0 +: DW]      = cap_arg_val_i;
    cap_out_tag[0 +: TW]      = cap_arg_tag_i;
    cap_out_val[DW +: DW]     = new_handle;
    cap_out_tag[TW +: TW]     = TAG_CONT;
    cap_out_val[7*DW +: DW]   = DW'(cap_op_i);
    cap_out_tag[7*TW +: TW]   = TAG_INT;
  end

  assign res_slot = res_handle_val_i[AW-1:OFFW];
  assign res_ok   = (res_handle_tag_i == TAG_CONT)
                 && (res_handle_val_i[DW-1:AW] == REGION_BASE[DW-1:AW])
                 && (res_handle_val_i[OFFW-1:0] == OFFW'(1))
                 && ({1'b0, res_slot} < (SW+1)'(NUM_SLOTS));

  assign hdr_ok = (mem_rdata_i[15:8] == MARK_FRESH) && (mem_rdata_i[3:0] == LAYOUT_CONT);

  assign wr_reg = off_reg(cnt_q);
  assign rd_reg = off_reg(rd_off_q);

  always_comb begin
    case (int'(cnt_q))
      OFF_HDR:  cap_word = {MARK_FRESH, SIZE_ESC, LAYOUT_CONT};
      OFF_SIZE: cap_word = DW'(PAYLOAD_WORDS);
      OFF_PC:   cap_word = pc_q;
      OFF_SP:   cap_word = sp_q;
      OFF_PSP:  cap_word = psp_q;
      default:  cap_word = cnt_q[0] ? regv_q[wr_reg*DW +: DW] : DW'(regt_q[wr_reg*TW +: TW]);
    endcase
  end

  // memory port
  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = {slot_q, cnt_q};
    mem_wdata_o = cap_word;
    case (state_q)
      S_CAPW: mem_we_o = 1'b1;
      S_RHDR: begin
        mem_re_o   = 1'b1;
        mem_addr_o = {slot_q, OFFW'(OFF_HDR)};
      end
      S_RCHK: begin
        mem_we_o    = hdr_ok;
        mem_addr_o  = {slot_q, OFFW'(OFF_HDR)};
        mem_wdata_o = {MARK_USED, mem_rdata_i[7:0]};
      end
      S_RRD:   mem_re_o = 1'b1;
      default: ;
    endcase
  end

  assign pop_o       = (state_q == S_IDLE) && cap_start_i && avail_i;
  assign push_o      = (state_q == S_RDRAIN);
  assign push_slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      is_cap_q  <= 1'b0;
      flag_q    <= 1'b0;
      slot_q    <= '0;
      cnt_q     <= '0;
      rd_off_q  <= '0;
      rd_pend_q <= 1'b0;
      pc_q      <= '0;
      sp_q      <= '0;
      psp_q     <= '0;
      regv_q    <= '0;
      regt_q    <= '0;
      out_val_q <= '0;
      out_tag_q <= '0;
      out_pc_q  <= '0;
      out_sp_q  <= '0;
      dv_q      <= '0;
      dt_q      <= '0;
    end else begin
      rd_pend_q <= (state_q == S_RRD);
      rd_off_q  <= cnt_q;
      if (rd_pend_q) begin
        case (int'(rd_off_q))
          OFF_PC:  out_pc_q <= mem_rdata_i;
          OFF_SP:  out_sp_q <= mem_rdata_i;
          OFF_PSP: ;
          default: begin
            if (rd_off_q[0]) out_val_q[rd_reg*DW +: DW] <= mem_rdata_i;
            else             out_tag_q[rd_reg*TW +: TW] <= mem_rdata_i[TW-1:0];
          end
        endcase
      end

      case (state_q)
        S_IDLE: begin
          if (cap_start_i) begin
            is_cap_q <= 1'b1;
            if (avail_i) begin
              flag_q    <= 1'b0;
              slot_q    <= pop_slot_i;
              cnt_q     <= '0;
              pc_q      <= cap_pc_i + DW'(1);
              sp_q      <= cap_sp_i;
              psp_q     <= cap_psp_i;
              regv_q    <= cap_reg_val_i;
              regt_q    <= cap_reg_tag_i;
              out_val_q <= cap_out_val;
              out_tag_q <= cap_out_tag;
              out_pc_q  <= cap_pc_i + DW'(1);
              out_sp_q  <= cap_sp_i;
              state_q   <= S_CAPW;
            end else begin
              flag_q  <= 1'b1;
              state_q <= S_FIN;
            end
          end else if (res_start_i) begin
            is_cap_q <= 1'b0;
            slot_q   <= res_slot;
            dv_q     <= res_value_val_i;
            dt_q     <= res_value_tag_i;
            flag_q   <= !res_ok;
            state_q  <= res_ok ? S_RHDR : S_FIN;
          end
        end
        S_CAPW: begin
          cnt_q <= cnt_q + OFFW'(1);
          if (cnt_q == OFFW'(OFF_LAST)) state_q <= S_FIN;
        end
        S_RHDR: state_q <= S_RCHK;
        S_RCHK: begin
          if (hdr_ok) begin
            cnt_q   <= OFFW'(OFF_PC);
            state_q <= S_RRD;
          end else begin
            flag_q  <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_RRD: begin
          cnt_q <= cnt_q + OFFW'(1);
          if (cnt_q == OFFW'(OFF_LAST)) state_q <= S_RDRAIN;
        end
        S_RDRAIN: begin
          // last read word is the v7 tag, so v0 can be overwritten here
          out_val_q[0 +: DW] <= dv_q;
          out_tag_q[0 +: TW] <= dt_q;
          state_q            <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == S_IDLE);
  assign cap_done_o = (state_q == S_FIN) && is_cap_q;
  assign res_done_o = (state_q == S_FIN) && !is_cap_q;
  assign exhaust_o  = cap_done_o && flag_q;
  assign trap_o     = res_done_o && flag_q;
  assign reg_val_o  = out_val_q;
  assign reg_tag_o  = out_tag_q;
  assign pc_o       = out_pc_q;
  assign sp_o       = out_sp_q;
endmodule

// File: rtl/cont_rec_engine.sv
module cont_rec_engine import cre_pkg::*; #(
  parameter int            NUM_SLOTS   = 4,
  parameter logic [15:0]   REGION_BASE = 16'hC000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_start_i,
  input  logic [DW-1:0]        cap_pc_i,
  input  logic [DW-1:0]        cap_sp_i,
  input  logic [DW-1:0]        cap_psp_i,
  input  logic [NREG*DW-1:0]   cap_reg_val_i,
  input  logic [NREG*TW-1:0]   cap_reg_tag_i,
  input  logic [DW-1:0]        cap_arg_val_i,
  input  logic [TW-1:0]        cap_arg_tag_i,
  input  logic [3:0]           cap_op_i,
  input  logic                 res_start_i,
  input  logic [DW-1:0]        res_handle_val_i,
  input  logic [TW-1:0]        res_handle_tag_i,
  input  logic [DW-1:0]        res_value_val_i,
  input  logic [TW-1:0]        res_value_tag_i,
  output logic                 idle_o,
  output logic                 cap_done_o,
  output logic                 res_done_o,
  output logic                 exhaust_o,
  output logic                 trap_o,
  output logic [NREG*DW-1:0]   reg_val_o,
  output logic [NREG*TW-1:0]   reg_tag_o,
  output logic [DW-1:0]        pc_o,
  output logic [DW-1:0]        sp_o
);
  localparam int SW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int AW    = SW + OFFW;
  localparam int DEPTH = NUM_SLOTS << OFFW;

  logic          pool_avail, pool_pop, pool_push;
  logic [SW-1:0] pool_pop_slot, pool_push_slot;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  cre_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pool_pop),
    .push_i      (pool_push),
    .push_slot_i (pool_push_slot),
    .avail_o     (pool_avail),
    .pop_slot_o  (pool_pop_slot)
  );

  cre_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  cre_seq #(
    .NUM_SLOTS(NUM_SLOTS), .REGION_BASE(REGION_BASE), .SW(SW), .AW(AW)
  ) u_seq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cap_start_i      (cap_start_i),
    .cap_pc_i         (cap_pc_i),
    .cap_sp_i         (cap_sp_i),
    .cap_psp_i        (cap_psp_i),
    .cap_reg_val_i    (cap_reg_val_i),
    .cap_reg_tag_i    (cap_reg_tag_i),
    .cap_arg_val_i    (cap_arg_val_i),
    .cap_arg_tag_i    (cap_arg_tag_i),
    .cap_op_i         (cap_op_i),
    .res_start_i      (res_start_i),
    .res_handle_val_i (res_handle_val_i),
    .res_handle_tag_i (res_handle_tag_i),
    .res_value_val_i  (res_value_val_i),
    .res_value_tag_i  (res_value_tag_i),
    .avail_i          (pool_avail),
    .pop_slot_i       (pool_pop_slot),
    .pop_o            (pool_pop),
    .push_o           (pool_push),
    .push_slot_o      (pool_push_slot),
    .mem_we_o         (mem_we),
    .mem_re_o         (mem_re),
    .mem_addr_o       (mem_addr),
    .mem_wdata_o      (mem_wdata),
    .mem_rdata_i      (mem_rdata),
    .idle_o           (idle_o),
    .cap_done_o       (cap_done_o),
    .res_done_o       (res_done_o),
    .exhaust_o        (exhaust_o),
    .trap_o           (trap_o),
    .reg_val_o        (reg_val_o),
    .reg_tag_o        (reg_tag_o),
    .pc_o             (pc_o),
    .sp_o             (sp_o)
  );
endmodule

// File: rtl/cre_checker.sv
module cre_checker import cre_pkg::*; (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cap_start_i,
  input logic          res_start_i,
  input logic [TW-1:0] res_handle_tag_i,
  input logic          idle_o,
  input logic          cap_done_o,
  input logic          res_done_o,
  input logic          trap_o,
  input logic          exhaust_o,
  input logic [TW-1:0] v1_tag,
  input logic [TW-1:0] v7_tag,
  input logic          mem_we
);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done_o || res_done_o) |=> !(cap_done_o || res_done_o));

  p_done_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cap_done_o, res_done_o}));

  p_busy_after_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && (cap_start_i || res_start_i)) |=> !idle_o);

  p_trap_kind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> res_done_o);

  p_exhaust_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhaust_o |-> cap_done_o);

  p_exhaust_nowrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhaust_o |-> !$past(mem_we));

  p_idle_nowrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_we);

  p_badtag_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && res_start_i && !cap_start_i && res_handle_tag_i != TAG_CONT)
      |=> (res_done_o && trap_o));

  p_handle_tags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done_o && !exhaust_o) |-> (v1_tag == TAG_CONT && v7_tag == TAG_INT));
endmodule

bind cont_rec_engine cre_checker u_cre_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cap_start_i      (cap_start_i),
  .res_start_i      (res_start_i),
  .res_handle_tag_i (res_handle_tag_i),
  .idle_o           (idle_o),
  .cap_done_o       (cap_done_o),
  .res_done_o       (res_done_o),
  .trap_o           (trap_o),
  .exhaust_o        (exhaust_o),
  .v1_tag           (reg_tag_o[5:3]),
  .v7_tag           (reg_tag_o[23:21]),
  .mem_we           (mem_we)
);

// File: tb/cont_rec_engine_bench.sv
`timescale 1ns/1ps
module cont_rec_engine_bench;
  localparam int NS = 4;
  localparam logic [15:0] BASE = 16'hC000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         cap_start = 1'b0, res_start = 1'b0;
  logic [15:0]  cap_pc = '0, cap_sp = '0, cap_psp = '0, cap_arg_val = '0;
  logic [127:0] cap_rv = '0;
  logic [23:0]  cap_rt = '0;
  logic [2:0]   cap_arg_tag = '0;
  logic [3:0]   cap_op = '0;
  logic [15:0]  h_val = '0, d_val = '0;
  logic [2:0]   h_tag = '0, d_tag = '0;
  logic         idle, cdone, rdone, exh, trap;
  logic [127:0] rv;
  logic [23:0]  rt;
  logic [15:0]  pc, sp;

  cont_rec_engine u_cont_rec_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cap_start_i(cap_start), .cap_pc_i(cap_pc), .cap_sp_i(cap_sp), .cap_psp_i(cap_psp),
    .cap_reg_val_i(cap_rv), .cap_reg_tag_i(cap_rt),
    .cap_arg_val_i(cap_arg_val), .cap_arg_tag_i(cap_arg_tag), .cap_op_i(cap_op),
    .res_start_i(res_start), .res_handle_val_i(h_val), .res_handle_tag_i(h_tag),
    .res_value_val_i(d_val), .res_value_tag_i(d_tag),
    .idle_o(idle), .cap_done_o(cdone), .res_done_o(rdone), .exhaust_o(exh), .trap_o(trap),
    .reg_val_o(rv), .reg_tag_o(rt), .pc_o(pc), .sp_o(sp)
  );

  typedef struct {
    bit           is_cap;
    bit           flag;
    logic [127:0] v;
    logic [23:0]  t;
    logic [15:0]  pc;
    logic [15:0]  sp;
    string        req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0;

  // reference slot model
  int           fstack[$];
  int           fresh = 0;
  bit           live[NS];
  logic [127:0] rec_v[NS];
  logic [23:0]  rec_t[NS];
  logic [15:0]  rec_pc[NS], rec_sp[NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: compare each finished operation with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && (cdone || rdone)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 128'(cdone), 128'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cdone == e.is_cap, e.req, "operation kind", 128'(cdone), 128'(e.is_cap));
        chk((e.is_cap ? exh : trap) == e.flag, e.req, "trap/exhaust flag",
            128'(e.is_cap ? exh : trap), 128'(e.flag));
        if (!e.flag) begin
          chk(rv == e.v, e.req, "register values", rv, e.v);
          chk(rt == e.t, e.req, "register tags", 128'(rt), 128'(e.t));
          chk(pc == e.pc, e.req, "pc", 128'(pc), 128'(e.pc));
          chk(sp == e.sp, e.req, "sp", 128'(sp), 128'(e.sp));
        end
      end
    end
  end

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 64 && !(cdone || rdone); i++) @(negedge clk);
    chk(cdone || rdone, req, "done seen", 128'(i), 128'd0);
  endtask

  task automatic do_cap(input logic [15:0] p, input logic [15:0] s, input logic [15:0] ps,
                        input logic [15:0] av, input logic [2:0] at, input logic [3:0] op,
                        input string req, output logic [15:0] handle);
    exp_t e;
    int slot;
    logic [127:0] v;
    logic [23:0] t;
    v = {$urandom(), $urandom(), $urandom(), $urandom()};
    t = 24'($urandom());
    if (fstack.size() > 0) slot = fstack.pop_back();
    else if (fresh < NS) begin slot = fresh; fresh++; end
    else slot = -1;
    e.is_cap = 1'b1;
    e.req = req;
    e.flag = (slot < 0);
    handle = '0;
    e.v = v; e.t = t; e.pc = p + 16'd1; e.sp = s;
    if (slot >= 0) begin
      handle = BASE + 16'(slot * 32 + 1);
      e.v[0 +: 16] = av;       e.t[0 +: 3] = at;
      e.v[16 +: 16] = handle;  e.t[3 +: 3] = 3'd2;
      e.v[112 +: 16] = 16'(op); e.t[21 +: 3] = 3'd0;
      live[slot] = 1'b1;
      rec_v[slot] = v; rec_t[slot] = t; rec_pc[slot] = p + 16'd1; rec_sp[slot] = s;
    end
    sb.push_back(e);
    @(negedge clk);
    cap_pc = p; cap_sp = s; cap_psp = ps; cap_rv = v; cap_rt = t;
    cap_arg_val = av; cap_arg_tag = at; cap_op = op;
    cap_start = 1'b1;
    @(negedge clk);
    cap_start = 1'b0;
    chk(!idle, "R11", "idle low after capture start", 128'(idle), 128'd0);
    wait_done(req);
  endtask

  task automatic do_res(input logic [15:0] hv, input logic [2:0] ht,
                        input logic [15:0] dv, input logic [2:0] dt, input string req);
    exp_t e;
    int slot;
    bit ok;
    slot = int'(hv[6:5]);
    ok = (ht == 3'd2) && (hv[15:7] == BASE[15:7]) && (hv[4:0] == 5'd1) && live[slot];
    e.is_cap = 1'b0;
    e.req = req;
    e.flag = !ok;
    e.v = '0; e.t = '0; e.pc = '0; e.sp = '0;
    if (ok) begin
      e.v = rec_v[slot]; e.t = rec_t[slot];
      e.v[0 +: 16] = dv; e.t[0 +: 3] = dt;
      e.pc = rec_pc[slot]; e.sp = rec_sp[slot];
      live[slot] = 1'b0;
      fstack.push_back(slot);
    end
    sb.push_back(e);
    @(negedge clk);
    h_val = hv; h_tag = ht; d_val = dv; d_tag = dt;
    res_start = 1'b1;
    @(negedge clk);
    res_start = 1'b0;
    if (ht != 3'd2)
      chk(rdone && trap, "R5", "trap one cycle after start", 128'({rdone, trap}), 128'b11);
    wait_done(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] ha, hb, hc, hd, he, hf, hg, hh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(idle && !cdone && !rdone && !trap && !exh, "R1", "reset outputs",
        128'({idle, cdone, rdone, trap, exh}), 128'b10000);

    // R2 R3 fresh captures, ascending slots
    do_cap(16'h0100, 16'h7F00, 16'h7F80, 16'h1234, 3'd0, 4'h5, "R3", ha);
    chk(ha == 16'hC001, "R2", "first handle", 128'(ha), 128'hC001);
    do_cap(16'h0200, 16'h7E00, 16'h7E40, 16'hBEEF, 3'd1, 4'hF, "R3", hb);
    chk(hb == 16'hC021, "R2", "second handle", 128'(hb), 128'hC021);
    do_cap(16'hFFFF, 16'h0010, 16'h0020, 16'h0000, 3'd4, 4'h0, "R3", hc);

    // R4 resume with delivered BOOL
    do_res(hb, 3'd2, 16'h0001, 3'd5, "R4");
    // R7 second resume of a consumed record
    do_res(hb, 3'd2, 16'h0002, 3'd0, "R7");

    // R8 freed slot reused before fresh one
    do_cap(16'h0300, 16'h7D00, 16'h7D10, 16'h5555, 3'd3, 4'h9, "R8", hd);
    chk(hd == 16'hC021, "R8", "reused handle", 128'(hd), 128'hC021);
    do_cap(16'h0400, 16'h7C00, 16'h7C10, 16'hAAAA, 3'd0, 4'h1, "R2", he);
    chk(he == 16'hC061, "R2", "fresh slot 3 handle", 128'(he), 128'hC061);

    // R9 exhaustion
    do_cap(16'h0500, 16'h7B00, 16'h7B10, 16'h0F0F, 3'd0, 4'h2, "R9", hf);

    // R5 R6 rejected handles
    do_res(ha, 3'd0, 16'h1111, 3'd0, "R5");
    do_res(16'hC002, 3'd2, 16'h2222, 3'd0, "R6");
    do_res(16'h4001, 3'd2, 16'h3333, 3'd0, "R6");

    // R9 R10 all live records resume intact; slot 1 holds the reused record
    do_res(ha, 3'd2, 16'h4444, 3'd0, "R9");
    do_res(hc, 3'd2, 16'h5555, 3'd3, "R9");
    do_res(hd, 3'd2, 16'h6666, 3'd1, "R10");
    do_res(he, 3'd2, 16'h7777, 3'd0, "R9");

    // R8 LIFO order of freed slots: 3 then 1
    do_cap(16'h0600, 16'h7A00, 16'h7A10, 16'h1357, 3'd0, 4'h7, "R8", hg);
    chk(hg == 16'hC061, "R8", "most recent free slot", 128'(hg), 128'hC061);
    do_cap(16'h0700, 16'h7900, 16'h7910, 16'h2468, 3'd1, 4'hC, "R8", hh);
    chk(hh == 16'hC021, "R8", "next free slot", 128'(hh), 128'hC021);
    do_res(hg, 3'd2, 16'h8888, 3'd2, "R10");
    do_res(hh, 3'd2, 16'h9999, 3'd0, "R10");
    do_res(hh, 3'd2, 16'hAAAA, 3'd0, "R7");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11", "all results seen", 128'(sb.size()), 128'd0);
    chk(idle, "R11", "idle at end", 128'(idle), 128'd1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule